// File: doc/BRIEF.md
# Sample Rate Class Reporter

This block estimates the sample rate of a received audio stream. It counts rising edges of a free-running local reference clock over windows of whole frames, then maps the count to one of six rate classes. The reference runs at a nominal 6.144 MHz. The frame rate comes from the receiver as a one-cycle frame strobe. A block-start flag marks frame 0 of each 192-frame status block.

Each status block is split into three back-to-back windows of 64 frames. The windows are aligned to the block boundary, and a new code is published at frames 0, 64 and 128. The code is trusted only after the reference has shown edges through two whole windows, which is two thirds of a block. If the reference goes quiet for a full window, the trust flag drops. The outputs are driven only while the status-select input is low; while it is high they read as zero.

Top module: `rate_class_reporter`

## Requirements
- R1: After reset, `rate_code` is 0 and `rate_valid` is 0.
- R2: While `sel_status` is high, `rate_code` reads 0 and `rate_valid` reads 0. When `sel_status` returns low, the held result is shown again without a new measurement.
- R3: A window count inside the band of a class gives that class code: 1 = 32 kHz, 2 = 44.1 kHz, 3 = 48 kHz, 4 = 64 kHz, 5 = 88.2 kHz, 6 = 96 kHz. Each band runs from ceil(0.96·N) to floor(1.04·N), where N = 64·REF_HZ/rate. The bands do not overlap.
- R4: A window count that falls in no band gives code 0.
- R5: A frame strobe is a boundary when it either carries block start or comes after the first block start, and its block frame index is 0, 64 or 128. A new code is loaded only on such a strobe, and it appears one clock after that strobe. At every other time the code is held.
- R6: Until the first frame strobe that carries block start, no result is published and the code stays 0. The boundary of that first block start only opens a window.
- R7: `rate_valid` rises only at a boundary that ends the second window in a row with at least one reference edge. At the first such boundary it is still 0.
- R8: After 64 frame strobes with no reference rising edge, `rate_valid` goes to 0 and the run of good windows restarts from zero. It stays at 1 while the gap is shorter than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous, sampled internally |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| blk_start | input | 1 | With `frame_stb`, marks frame 0 of a status block |
| sel_status | input | 1 | High selects status display; the reporter outputs read 0 |
| rate_code | output | 3 | Rate class code, 0 = out of range |
| rate_valid | output | 1 | Reference present long enough for the code to be trusted |

## Verification
A window counter or band table that is off shows at the ports as the wrong class code at the next boundary, which is at most 64 frames later. A misaligned frame index moves the code change away from frames 0, 64 and 128, and the bench sees this when it samples one frame early and on the boundary. A fault in the good-window run or the gap counter shows as `rate_valid` rising one window too early, or falling too early or too late. The bench probes both points: at 30 and 70 frames of silence, and at the first two boundaries after the reference returns.

// File: rtl/rcr_pkg.sv
`timescale 1ns/1ps
package rcr_pkg;

   localparam int NUM_CLASSES = 6;

   // Ordered by class code minus one; codes follow this order.
   localparam int unsigned CLASS_HZ [NUM_CLASSES] =
      '{32000, 44100, 48000, 64000, 88200, 96000};

   // Lowest count accepted for a class: ceil(win*ref*(100-tol)/(100*fs)).
   function automatic int unsigned band_lo(input int unsigned win,
                                           input int unsigned ref_hz,
                                           input int unsigned tol,
                                           input int unsigned fs);
      longint unsigned num;
      longint unsigned den;
      num = 64'(win) * 64'(ref_hz) * 64'(100 - tol);
      den = 64'(fs) * 64'd100;
      return 32'((num + den - 64'd1) / den);
   endfunction

   // Highest count accepted for a class: floor(win*ref*(100+tol)/(100*fs)).
   function automatic int unsigned band_hi(input int unsigned win,
                                           input int unsigned ref_hz,
                                           input int unsigned tol,
                                           input int unsigned fs);
      longint unsigned num;
      longint unsigned den;
      num = 64'(win) * 64'(ref_hz) * 64'(100 + tol);
      den = 64'(fs) * 64'd100;
      return 32'(num / den);
   endfunction

endpackage

// File: rtl/rcr_ref_edge.sv
`timescale 1ns/1ps
module rcr_ref_edge #(
   parameter int SYNC_STAGES = 2,
   parameter int GAP_LIMIT   = 64,
   localparam int GAP_W      = $clog2(GAP_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_async,
   input  logic frame_stb,
   output logic edge_o,
   output logic stale_o
);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("rcr_ref_edge: SYNC_STAGES below 2");
      assert (GAP_LIMIT >= 1) else $error("rcr_ref_edge: GAP_LIMIT below 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [GAP_W-1:0]       gap_q;
   logic                   ref_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ref_async};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ref_s  = sync_q[SYNC_STAGES-1];
   assign edge_o = ref_s & ~prev_q;

   // Frames since the last reference edge, saturating at the limit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= GAP_W'(GAP_LIMIT);
      end else if (edge_o) begin
         gap_q <= '0;
      end else if (frame_stb && (gap_q != GAP_W'(GAP_LIMIT))) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   assign stale_o = (gap_q == GAP_W'(GAP_LIMIT));

   AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= GAP_W'(GAP_LIMIT)) else $error("gap counter overran");            // R8

   AST_EDGE_CLEARS_STALE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !stale_o) else $error("stale after reference edge");             // R8

endmodule

// File: rtl/rcr_frame_seq.sv
`timescale 1ns/1ps
module rcr_frame_seq #(
   parameter int BLOCK_FRAMES = 192,
   parameter int UPDATES      = 3,
   localparam int WIN         = BLOCK_FRAMES / UPDATES,
   localparam int IDX_W       = $clog2(BLOCK_FRAMES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic blk_start,
   output logic boundary_o,
   output logic publish_o,
   output logic locked_o
);

   initial begin
      assert (UPDATES >= 1) else $error("rcr_frame_seq: UPDATES below 1");
      assert (BLOCK_FRAMES % UPDATES == 0)
         else $error("rcr_frame_seq: block not a whole number of windows");
   end

   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   idx_next;
   logic               locked_q;
   logic [UPDATES-1:0] at_start;

   always_comb begin
      if (blk_start) begin
         idx_next = '0;
      end else if (idx_q == IDX_W'(BLOCK_FRAMES - 1)) begin
         idx_next = '0;
      end else begin
         idx_next = idx_q + 1'b1;
      end
   end

   for (genvar k = 0; k < UPDATES; k++) begin : g_win_start
      assign at_start[k] = (idx_next == IDX_W'(k * WIN));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         locked_q <= 1'b0;
      end else if (frame_stb && (blk_start || locked_q)) begin
         idx_q    <= idx_next;
         locked_q <= 1'b1;
      end
   end

   assign boundary_o = frame_stb && (blk_start || locked_q) && (|at_start);
   assign publish_o  = boundary_o && locked_q;
   assign locked_o   = locked_q;

   AST_IDX_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q < IDX_W'(BLOCK_FRAMES)) else $error("frame index left the block"); // R5

   AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q) else $error("alignment lost");                     // R6

endmodule

// File: rtl/rcr_classify.sv
`timescale 1ns/1ps
module rcr_classify #(
   parameter int unsigned REF_HZ  = 6144000,
   parameter int unsigned WIN     = 64,
   parameter int unsigned TOL_PCT = 4,
   parameter int          CNT_W   = 16,
   parameter int          CODE_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [CODE_W-1:0] code_o
);
   import rcr_pkg::*;

   initial begin
      assert (CNT_W <= 32) else $error("rcr_classify: CNT_W above 32");
      assert (NUM_CLASSES < (1 << CODE_W)) else $error("rcr_classify: CODE_W too small");
      assert (TOL_PCT < 100) else $error("rcr_classify: tolerance too wide");
   end

   logic [31:0]            cnt32;
   logic [NUM_CLASSES-1:0] hit;

   assign cnt32 = 32'(cnt_i);

   for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_band
      localparam int unsigned LO = band_lo(WIN, REF_HZ, TOL_PCT, CLASS_HZ[i]);
      localparam int unsigned HI = band_hi(WIN, REF_HZ, TOL_PCT, CLASS_HZ[i]);
      assign hit[i] = (cnt32 >= LO) && (cnt32 <= HI);
   end

   // Lowest class index wins should bands ever touch.
   always_comb begin
      code_o = '0;
      for (int i = NUM_CLASSES - 1; i >= 0; i--) begin
         if (hit[i]) code_o = CODE_W'(i + 1);
      end
   end

   AST_BANDS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)) else $error("rate bands overlap");                         // R3

endmodule

// File: rtl/rate_class_reporter.sv
`timescale 1ns/1ps
module rate_class_reporter #(
   parameter int unsigned REF_HZ       = 6144000,
   parameter int          BLOCK_FRAMES = 192,
   parameter int          UPDATES      = 3,
   parameter int unsigned TOL_PCT      = 4,
   parameter int          CNT_W        = 16,
   parameter int          CODE_W       = 3,
   parameter int          SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_clk_in,
   input  logic              frame_stb,
   input  logic              blk_start,
   input  logic              sel_status,
   output logic [CODE_W-1:0] rate_code,
   output logic              rate_valid
);

   localparam int WIN    = BLOCK_FRAMES / UPDATES;
   localparam int NEED   = (2 * UPDATES + 2) / 3;
   localparam int PRES_W = $clog2(NEED + 1);

   initial begin
      assert (CNT_W >= 2) else $error("rate_class_reporter: CNT_W below 2");
      assert (NEED >= 1) else $error("rate_class_reporter: presence run below 1");
   end

   logic              ref_edge;
   logic              stale;
   logic              boundary;
   logic              publish;
   logic              locked;
   logic [CNT_W-1:0]  win_cnt_q;
   logic [CODE_W-1:0] class_code;
   logic [CODE_W-1:0] code_q;
   logic [PRES_W-1:0] present_q;
   logic [PRES_W-1:0] pres_inc;
   logic              valid_q;

   rcr_ref_edge #(
      .SYNC_STAGES (SYNC_STAGES),
      .GAP_LIMIT   (WIN)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_async (ref_clk_in),
      .frame_stb (frame_stb),
      .edge_o    (ref_edge),
      .stale_o   (stale)
   );

   rcr_frame_seq #(
      .BLOCK_FRAMES (BLOCK_FRAMES),
      .UPDATES      (UPDATES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_stb  (frame_stb),
      .blk_start  (blk_start),
      .boundary_o (boundary),
      .publish_o  (publish),
      .locked_o   (locked)
   );

   rcr_classify #(
      .REF_HZ  (REF_HZ),
      .WIN     (WIN),
      .TOL_PCT (TOL_PCT),
      .CNT_W   (CNT_W),
      .CODE_W  (CODE_W)
   ) u_cls (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_i  (win_cnt_q),
      .code_o (class_code)
   );

   // Reference edges in the current window, saturating.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt_q <= '0;
      end else if (boundary) begin
         win_cnt_q <= ref_edge ? CNT_W'(1) : '0;
      end else if (ref_edge && (win_cnt_q != '1)) begin
         win_cnt_q <= win_cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (publish) begin
         code_q <= class_code;
      end
   end

   assign pres_inc = (present_q == PRES_W'(NEED)) ? present_q : present_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present_q <= '0;
         valid_q   <= 1'b0;
      end else if (stale) begin
         present_q <= '0;
         valid_q   <= 1'b0;
      end else if (publish) begin
         if (win_cnt_q != '0) begin
            present_q <= pres_inc;
            valid_q   <= (pres_inc >= PRES_W'(NEED));
         end else begin
            present_q <= '0;
            valid_q   <= 1'b0;
         end
      end
   end

   assign rate_code  = sel_status ? '0 : code_q;
   assign rate_valid = valid_q & ~sel_status;

   AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !publish |=> $stable(code_q)) else $error("code moved off a boundary");    // R5

   AST_VALID_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (present_q >= PRES_W'(NEED))) else $error("valid too early"); // R7

   AST_STALE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      stale |=> !valid_q) else $error("valid kept without reference");          // R8

   AST_UNLOCKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> (code_q == '0)) else $error("code before alignment");         // R6

endmodule

// File: tb/rate_class_reporter_test.sv
`timescale 1ns/1ps
module rate_class_reporter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_clk_in = 1'b0;
   logic       frame_stb = 1'b0;
   logic       blk_start = 1'b0;
   logic       sel_status = 1'b0;
   logic [2:0] rate_code;
   logic       rate_valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Stimulus controls
   int frame_per = 16;
   int ref_half  = 2;
   bit ref_on    = 1'b0;
   bit blk_en    = 1'b0;
   int fc        = 0;
   int rc        = 0;
   int cur_idx   = 191;

   // Scaled reference so windows stay short: bands for 48 kHz are 246..266 etc.
   rate_class_reporter #(.REF_HZ(192000)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_clk_in (ref_clk_in),
      .frame_stb  (frame_stb),
      .blk_start  (blk_start),
      .sel_status (sel_status),
      .rate_code  (rate_code),
      .rate_valid (rate_valid)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (fc >= frame_per - 1) begin
         fc        <= 0;
         frame_stb <= 1'b1;
         cur_idx   <= (cur_idx == 191) ? 0 : cur_idx + 1;
         blk_start <= blk_en && (cur_idx == 191);
      end else begin
         fc        <= fc + 1;
         frame_stb <= 1'b0;
         blk_start <= 1'b0;
      end
      if (ref_on) begin
         if (rc >= ref_half - 1) begin
            rc         <= 0;
            ref_clk_in <= ~ref_clk_in;
         end else begin
            rc <= rc + 1;
         end
      end else begin
         ref_clk_in <= 1'b0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_idx(input int idx);
      do @(posedge clk); while (!(frame_stb && cur_idx == idx));
      #2;
   endtask

   task automatic wait_any_bnd();
      do @(posedge clk); while (!(frame_stb && (cur_idx % 64 == 0)));
      #2;
   endtask

   task automatic wait_frames(input int n);
      for (int i = 0; i < n; i++) begin
         do @(posedge clk); while (!frame_stb);
      end
      #2;
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #2;
      chk("R1 code", rate_code, 0);
      chk("R1 valid", rate_valid, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_no_align();
      ref_on = 1'b1;
      wait_frames(200);
      chk("R6 code unaligned", rate_code, 0);
      chk("R6 valid unaligned", rate_valid, 0);
   endtask

   task automatic t_first_block();
      blk_en = 1'b1;
      wait_idx(0);
      chk("R6 first block start", rate_code, 0);
      wait_idx(63);
      chk("R5 before boundary", rate_code, 0);
      wait_idx(64);
      chk("R3 48k code", rate_code, 3);
      chk("R7 one window", rate_valid, 0);
      wait_idx(127);
      chk("R5 held mid block", rate_code, 3);
      chk("R7 still short", rate_valid, 0);
      wait_idx(128);
      chk("R7 two windows", rate_valid, 1);
   endtask

   task automatic t_rate(input int fper, input int half, input int exp, input string req);
      frame_per = fper;
      ref_half  = half;
      wait_any_bnd();
      wait_any_bnd();
      chk(req, rate_code, exp);
      chk("R7 valid steady", rate_valid, 1);
   endtask

   task automatic t_sel();
      sel_status = 1'b1;
      @(posedge clk); #2;
      chk("R2 code gated", rate_code, 0);
      chk("R2 valid gated", rate_valid, 0);
      sel_status = 1'b0;
      @(posedge clk); #2;
      chk("R2 code restored", rate_code, 3);
      chk("R2 valid restored", rate_valid, 1);
   endtask

   task automatic t_loss();
      wait_any_bnd();
      ref_on = 1'b0;
      wait_frames(30);
      chk("R8 short gap keeps valid", rate_valid, 1);
      wait_frames(40);
      chk("R8 long gap drops valid", rate_valid, 0);
      wait_any_bnd();
      ref_on = 1'b1;
      wait_any_bnd();
      chk("R7 one window after loss", rate_valid, 0);
      wait_any_bnd();
      chk("R7 two windows after loss", rate_valid, 1);
   endtask

   initial begin
      t_reset();
      t_no_align();
      t_first_block();
      t_rate(17, 2, 2, "R3 44.1k code");
      t_rate(24, 2, 1, "R3 32k code");
      t_rate(12, 2, 4, "R3 64k code");
      t_rate(13, 3, 5, "R3 88.2k code");
      t_rate(8,  2, 6, "R3 96k code");
      t_rate(19, 2, 0, "R4 between bands");
      t_rate(40, 2, 0, "R4 above all bands");
      t_rate(16, 2, 3, "R3 48k again");
      t_sel();
      t_loss();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule